// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is a single compare channel of a general-purpose timer. An external counter supplies the running count and its direction. The channel compares that count against a programmed compare value under one of eight compare modes. From the result it keeps an internal active-high reference level. It then turns that level into the channel output pin through a polarity selection.

The compare modes are:
- a frozen mode;
- set, clear and toggle on a match;
- two forced levels;
- two pulse-width modes whose meaning depends on the counting direction.

An external clear input can pull the reference low when the clear feature is enabled. A 2-bit channel-direction field chooses between output use and three input-source selections. This field is locked against writes while the channel is enabled. Software programs the channel through a small write port: one control word and one compare value.

Top module: `occ_channel`

## Requirements
- R1: In compare mode 0 (frozen) the reference keeps its level whatever the counter and compare value do.
- R2: In mode 1 the reference goes high at the edge after a cycle in which count equals compare value; in mode 2 it goes low there; otherwise both modes hold the level.
- R3: In mode 3 the reference inverts at every edge that follows a cycle with count equal to the compare value, so it inverts again while the match persists.
- R4: Mode 4 drives the reference low and mode 5 drives it high, independent of the count.
- R5: In mode 6, counting up, the reference is high when count < compare value and low otherwise; counting down, it is low when count > compare value and high otherwise.
- R6: Mode 7 is the inverse of mode 6 in both directions: counting up, high when count >= compare value; counting down, high when count > compare value.
- R7: In modes 6 and 7 the reference takes the pulse-width level at the edge after the mode changes from frozen, and otherwise changes only when the raw count/compare result changes. Entering from any other mode with an unchanged result keeps the old level.
- R8: With clear enable set, a high clear input forces the reference low at the next edge in every mode. With clear enable clear, the clear input has no effect.
- R9: With polarity bit 0 the output equals the reference; with polarity bit 1 it is the inverted reference.
- R10: While the channel is disabled, or its direction field is not 00 (output), the output sits at its inactive level, which equals the polarity bit.
- R11: A control write changes the direction field only if the enable bit held before that write is 0. Otherwise the direction field keeps its value, while the other control bits still update.
- R12: After reset the reference and output are low, the mode is frozen, clear enable, polarity and enable are 0, and the direction field is 00.
- R13: The write port has two addresses. Address 0 is the control word: bits [2:0] mode, bit 3 clear enable, bit 4 polarity, bit 5 enable, bits [7:6] direction. Address 1 is the compare value. A write takes effect at its clock edge, and the reference reacts to counter or configuration state one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_val | input | CNT_W | Running counter value |
| cnt_down | input | 1 | 1 while the counter counts down |
| clr_in | input | 1 | External reference clear request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 control word, 1 compare value |
| wr_data | input | CFG_W | Write data |
| ref_o | output | 1 | Active-high reference level |
| ch_out | output | 1 | Channel output after polarity and gating |

## Verification
The external clear and the mode's own drive can act in the same cycle. The bench provokes this by asserting the clear input while forced-high mode is selected, and expects the clear to win. It then expects the forced level to return once the clear drops, and to return immediately when clear enable is off. A second overlap is a control write that tries to change the direction field while the enable bit it replaces is still set. Here the bench judges only the pin: the output must stay inactive until a write made with the channel disabled changes the field.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic [2:0] {
    CM_FROZEN = 3'd0,
    CM_SET    = 3'd1,
    CM_CLR    = 3'd2,
    CM_TOG    = 3'd3,
    CM_LOW    = 3'd4,
    CM_HIGH   = 3'd5,
    CM_PWM_A  = 3'd6,
    CM_PWM_B  = 3'd7
  } cmp_mode_e;

  localparam logic [1:0] DIR_OUTPUT = 2'b00;
  localparam logic       ADDR_CTRL  = 1'b0;
  localparam logic       ADDR_CMPV  = 1'b1;
endpackage

// File: rtl/occ_rst_sync.sv
module occ_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/occ_cfg_regs.sv
module occ_cfg_regs
  import occ_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CFG_W-1:0] wr_data,
  output cmp_mode_e        mode_q,
  output logic             clr_en_q,
  output logic             pol_q,
  output logic             en_q,
  output logic [1:0]       dir_q,
  output logic [CNT_W-1:0] cmpv_q
);
  logic             ctrl_we, cmpv_we;
  cmp_mode_e        mode_d;
  logic             clr_en_d, pol_d, en_d;
  logic [1:0]       dir_d;

  assign ctrl_we = wr_en && (wr_addr == ADDR_CTRL);
  assign cmpv_we = wr_en && (wr_addr == ADDR_CMPV);

  always_comb begin
    mode_d   = cmp_mode_e'(wr_data[2:0]);
    clr_en_d = wr_data[3];
    pol_d    = wr_data[4];
    en_d     = wr_data[5];
    // direction field is locked while the channel is enabled
    dir_d    = en_q ? dir_q : wr_data[7:6];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= CM_FROZEN;
      clr_en_q <= 1'b0;
      pol_q    <= 1'b0;
      en_q     <= 1'b0;
      dir_q    <= DIR_OUTPUT;
    end else if (ctrl_we) begin
      mode_q   <= mode_d;
      clr_en_q <= clr_en_d;
      pol_q    <= pol_d;
      en_q     <= en_d;
      dir_q    <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmpv_q <= '0;
    else if (cmpv_we) cmpv_q <= wr_data[CNT_W-1:0];
  end
endmodule

// File: rtl/occ_ref_gen.sv
module occ_ref_gen
  import occ_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_down,
  input  logic [CNT_W-1:0] cmpv,
  input  cmp_mode_e        mode,
  input  logic             clr_en,
  input  logic             clr_in,
  output logic             ref_q
);
  logic      ref_d;
  logic      raw_d, raw_q;
  logic      pwm_lvl;
  logic      hit;
  logic      from_frozen;
  cmp_mode_e mode_prev_q;

  assign hit = (cnt_val == cmpv);
  // raw result: level of the first pulse-width mode
  assign raw_d   = cnt_down ? !(cnt_val > cmpv) : (cnt_val < cmpv);
  assign pwm_lvl = (mode == CM_PWM_B) ? !raw_d : raw_d;
  assign from_frozen = (mode_prev_q == CM_FROZEN);

  always_comb begin
    ref_d = ref_q;
    unique case (mode)
      CM_FROZEN: ref_d = ref_q;
      CM_SET:    if (hit) ref_d = 1'b1;
      CM_CLR:    if (hit) ref_d = 1'b0;
      CM_TOG:    if (hit) ref_d = !ref_q;
      CM_LOW:    ref_d = 1'b0;
      CM_HIGH:   ref_d = 1'b1;
      CM_PWM_A,
      CM_PWM_B:  if (from_frozen || (raw_d != raw_q)) ref_d = pwm_lvl;
      default:   ref_d = ref_q;
    endcase
    if (clr_en && clr_in) ref_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q       <= 1'b0;
      raw_q       <= 1'b0;
      mode_prev_q <= CM_FROZEN;
    end else begin
      ref_q       <= ref_d;
      raw_q       <= raw_d;
      mode_prev_q <= mode;
    end
  end
endmodule

// File: rtl/occ_channel.sv
module occ_channel
  import occ_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int CFG_W = (CNT_W > 8) ? CNT_W : 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_down,
  input  logic             clr_in,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CFG_W-1:0] wr_data,
  output logic             ref_o,
  output logic             ch_out
);
  logic             rst_n_s;
  cmp_mode_e        mode_q;
  logic             clr_en_q, pol_q, en_q;
  logic [1:0]       dir_q;
  logic [CNT_W-1:0] cmpv_q;
  logic             drive_ok;

  occ_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s)
  );

  occ_cfg_regs #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_q(mode_q), .clr_en_q(clr_en_q),
    .pol_q(pol_q), .en_q(en_q), .dir_q(dir_q), .cmpv_q(cmpv_q)
  );

  occ_ref_gen #(.CNT_W(CNT_W)) u_ref (
    .clk(clk), .rst_n(rst_n_s), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .cmpv(cmpv_q), .mode(mode_q), .clr_en(clr_en_q), .clr_in(clr_in),
    .ref_q(ref_o)
  );

  assign drive_ok = en_q && (dir_q == DIR_OUTPUT);
  assign ch_out   = drive_ok ? (ref_o ^ pol_q) : pol_q;
endmodule

// File: rtl/occ_channel_chk.sv
module occ_channel_chk
  import occ_pkg::*;
(
  input logic       clk,
  input logic       rst_n_s,
  input logic       clr_in,
  input logic       wr_en,
  input logic       wr_addr,
  input logic       ref_o,
  input logic       ch_out,
  input cmp_mode_e  mode_q,
  input logic       clr_en_q,
  input logic       pol_q,
  input logic       en_q,
  input logic [1:0] dir_q
);
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (clr_en_q && clr_in) |=> !ref_o); // R8

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q == CM_HIGH && !(clr_en_q && clr_in)) |=> ref_o); // R4

  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q == CM_LOW) |=> !ref_o); // R4

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q == CM_FROZEN && !(clr_en_q && clr_in)) |=> $stable(ref_o)); // R1

  AST_DIR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (en_q && wr_en && wr_addr == ADDR_CTRL) |=> $stable(dir_q)); // R11

  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!en_q || dir_q != DIR_OUTPUT) |-> (ch_out == pol_q)); // R10
endmodule

bind occ_channel occ_channel_chk u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .clr_in(clr_in), .wr_en(wr_en),
  .wr_addr(wr_addr), .ref_o(ref_o), .ch_out(ch_out), .mode_q(mode_q),
  .clr_en_q(clr_en_q), .pol_q(pol_q), .en_q(en_q), .dir_q(dir_q)
);

// File: tb/occ_channel_tb.sv
`timescale 1ns/1ps
module occ_channel_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] cnt_val;
  logic         cnt_down, clr_in, wr_en, wr_addr;
  logic [7:0]   wr_data;
  logic         ref_o, ch_out;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  occ_channel #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .clr_in(clr_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ref_o(ref_o), .ch_out(ch_out)
  );

  function automatic logic [7:0] ctl(input int mode, input bit ce,
                                     input bit pol, input bit en,
                                     input int dir);
    return {dir[1:0], en, pol, ce, mode[2:0]};
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick(input int c, input bit dn, input bit clr);
    @(negedge clk); cnt_val = c[W-1:0]; cnt_down = dn; clr_in = clr;
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_val = '0; cnt_down = 1'b0; clr_in = 1'b0;
    wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    // R12 reset state
    check("R12 ref", ref_o, 1'b0);
    check("R12 out", ch_out, 1'b0);

    // R13 compare value at address 1
    wr(1'b1, 8'd10);

    // R1 frozen keeps high, then low
    wr(1'b0, ctl(5, 0, 0, 0, 0));
    tick(0, 0, 0); check("R4 force high", ref_o, 1'b1);
    wr(1'b0, ctl(0, 0, 0, 0, 0));
    for (int c = 0; c < 20; c++) begin tick(c, 0, 0); check("R1 frozen hold high", ref_o, 1'b1); end
    wr(1'b0, ctl(4, 0, 0, 0, 0));
    tick(10, 0, 0); check("R4 force low", ref_o, 1'b0);
    wr(1'b0, ctl(0, 0, 0, 0, 0));
    for (int c = 0; c < 20; c++) begin tick(c, 1, 0); check("R1 frozen hold low", ref_o, 1'b0); end

    // R2 set and clear on match
    wr(1'b0, ctl(1, 0, 0, 0, 0));
    tick(9, 0, 0);  check("R2 set no match", ref_o, 1'b0);
    tick(10, 0, 0); check("R2 set on match", ref_o, 1'b1);
    tick(11, 0, 0); check("R2 set holds", ref_o, 1'b1);
    wr(1'b0, ctl(2, 0, 0, 0, 0));
    tick(9, 0, 0);  check("R2 clear no match", ref_o, 1'b1);
    tick(10, 0, 0); check("R2 clear on match", ref_o, 1'b0);
    tick(3, 0, 0);  check("R2 clear holds", ref_o, 1'b0);

    // R3 toggle each matching cycle
    wr(1'b0, ctl(3, 0, 0, 0, 0));
    tick(10, 0, 0); check("R3 toggle 1", ref_o, 1'b1);
    tick(10, 0, 0); check("R3 toggle 2", ref_o, 1'b0);
    tick(11, 0, 0); check("R3 no match", ref_o, 1'b0);
    tick(10, 0, 0); check("R3 toggle 3", ref_o, 1'b1);

    // R5 / R6 sweeps, entered from frozen (R7)
    for (int m = 6; m <= 7; m++) begin
      for (int d = 0; d <= 1; d++) begin
        for (int k = 0; k < 4; k++) begin
          int cv;
          cv = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 128 : 255;
          wr(1'b1, cv[7:0]);
          wr(1'b0, ctl(0, 0, 0, 0, 0));
          wr(1'b0, ctl(m, 0, 0, 0, 0));
          for (int i = 0; i < 256; i++) begin
            int c;
            bit exp;
            c = (d == 1) ? 255 - i : i;
            if (d == 0) exp = (c < cv);
            else        exp = !(c > cv);
            if (m == 7) exp = !exp;
            tick(c, d[0], 0);
            if (m == 6) check("R5 pwm mode 6", ref_o, exp);
            else        check("R6 pwm mode 7", ref_o, exp);
          end
        end
      end
    end

    // R7 entry rules
    wr(1'b1, 8'd5);
    wr(1'b0, ctl(4, 0, 0, 0, 0));
    tick(3, 0, 0);
    wr(1'b0, ctl(6, 0, 0, 0, 0));
    tick(3, 0, 0); check("R7 entry from other mode holds", ref_o, 1'b0);
    tick(6, 0, 0); check("R7 result change low", ref_o, 1'b0);
    tick(2, 0, 0); check("R7 result change high", ref_o, 1'b1);
    wr(1'b0, ctl(4, 0, 0, 0, 0));
    wr(1'b0, ctl(0, 0, 0, 0, 0));
    tick(3, 0, 0); check("R7 frozen low", ref_o, 1'b0);
    wr(1'b0, ctl(6, 0, 0, 0, 0));
    tick(3, 0, 0); check("R7 entry from frozen updates", ref_o, 1'b1);

    // R8 clear input
    wr(1'b0, ctl(5, 1, 0, 0, 0));
    tick(0, 0, 1); check("R8 clear beats force high", ref_o, 1'b0);
    tick(0, 0, 0); check("R8 released", ref_o, 1'b1);
    wr(1'b0, ctl(5, 0, 0, 0, 0));
    tick(0, 0, 1); check("R8 clear disabled no effect", ref_o, 1'b1);
    tick(0, 0, 0);

    // R10 / R11 direction field and gating, ref held high
    wr(1'b0, ctl(5, 0, 0, 0, 1));
    tick(0, 0, 0); check("R10 disabled inactive", ch_out, 1'b0);
    wr(1'b0, ctl(5, 0, 0, 1, 1));
    tick(0, 0, 0); check("R10 input dir inactive", ch_out, 1'b0);
    wr(1'b0, ctl(5, 0, 0, 1, 0));
    tick(0, 0, 0); check("R11 locked write ignored", ch_out, 1'b0);
    wr(1'b0, ctl(5, 0, 0, 0, 1));
    wr(1'b0, ctl(5, 0, 0, 1, 0));
    tick(0, 0, 0); check("R11 unlocked write taken", ch_out, 1'b1);
    // R9 polarity
    wr(1'b0, ctl(5, 0, 1, 1, 0));
    tick(0, 0, 0); check("R9 inverted", ch_out, 1'b0);
    wr(1'b0, ctl(4, 0, 1, 1, 0));
    tick(0, 0, 0); check("R9 inverted low ref", ch_out, 1'b1);
    wr(1'b0, ctl(4, 0, 0, 1, 0));
    tick(0, 0, 0); check("R9 direct low ref", ch_out, 1'b0);
    wr(1'b0, ctl(5, 0, 1, 0, 0));
    tick(0, 0, 0); check("R10 inactive equals polarity", ch_out, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule